// File: doc/BRIEF.md
# Indexed Absolute Load Bus Sequencer

This block drives the external bus for one absolute-indexed load on a processor with an 8-bit data bus and a 24-bit address space. A start pulse launches the sequence. The block reads the opcode byte and then the two operand bytes at consecutive program-counter addresses in the program bank. It then adds the 16-bit index to the 24-bit pointer formed by the data bank and the operand, and reads one or two data bytes at the result.

When the sum of the index low byte and the operand low byte carries out, the block inserts one extra bus cycle before the data reads. During that cycle the address is only partly corrected: it carries the summed low byte together with the uncorrected operand high byte and data bank. The read strobe is high in that cycle, but both validity qualifiers are low, so outside decode logic can suppress the stray access. This happens in both emulation and native mode.

In emulation mode the index is cut to 8 bits and the data width to 8 bits. When the load finishes, the block pulses a done flag together with the loaded value and moves its program counter on by three.

Top module: `idx_abs_seq`

## Requirements
- R1: After start is accepted, the first three bus cycles present {pbank, pc}, {pbank, pc+1} and {pbank, pc+2}, where the 16-bit sum wraps within the bank. The opcode cycle has prog_ok=1 and data_ok=1. The two operand cycles have prog_ok=1 and data_ok=0. The operand low byte is read in the second cycle and the high byte in the third.
- R2: The effective address is ({dbank, op_hi, op_lo} + zero-extended index) modulo 2^24, so carries propagate into the high byte and then into the bank byte.
- R3: If op_lo + index[7:0] exceeds 0xFF, one cycle is inserted right after the operand-high fetch. It presents {dbank, op_hi, (op_lo+index[7:0]) mod 256} with rd=1, prog_ok=0 and data_ok=0. The bus data in this cycle does not affect the loaded value.
- R4: If there is no low-byte carry, no extra cycle occurs and the first data read follows the operand-high fetch directly.
- R5: Data reads have rd=1, prog_ok=0 and data_ok=1. The low byte is read at the effective address. When the width is 16 bits, the high byte is read in the next cycle at the effective address + 1 (modulo 2^24).
- R6: When emu=1, index[15:8] is treated as zero and the width is 8 bits whatever wide is. The extra cycle of R3 still occurs on a low-byte carry.
- R7: In the cycle after the last data read, done is high for exactly one cycle. value is {high, low} for 16-bit width or {0x00, low} for 8-bit width, and pc has advanced by 3 from its value at start.
- R8: A start pulse that arrives while a sequence is running is ignored: the bus cycle sequence and the result do not change.
- R9: After synchronous reset, rd, prog_ok, data_ok and done are 0, addr is 0, value is 0 and pc equals RESET_PC. Outside a sequence, rd and both qualifiers stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins one load sequence when idle |
| din | input | 8 | Read data bus |
| pbank | input | 8 | Program bank, sampled at start |
| dbank | input | 8 | Data bank, sampled at start |
| index | input | 16 | Index register, sampled at start |
| emu | input | 1 | Emulation mode, sampled at start |
| wide | input | 1 | 16-bit data width in native mode, sampled at start |
| addr | output | 24 | Bus address |
| rd | output | 1 | Read strobe |
| prog_ok | output | 1 | Valid program-address qualifier |
| data_ok | output | 1 | Valid data-address qualifier |
| done | output | 1 | One-cycle completion pulse |
| value | output | 16 | Loaded value |
| pc | output | 16 | Program counter |

## Verification
The bench runs the worked case (bank 0x15, operand 0x400A, index 0xDFFF). A design that left out the partly corrected cycle, or that had already fixed its high byte, would show the wrong address sequence there. It also runs loads that carry into the bank byte and a 16-bit load whose second byte crosses a page. A design that propagated carries only within 16 bits would read from the wrong bank in these cases. Emulation runs use a nonzero index high byte and the wide flag set, which catches a design that leaks those bits through or reads two bytes. A start pulse in the middle of a sequence would show up as extra or repeated bus cycles if the design did not ignore it.

// File: rtl/idx_abs_seq.sv
module idx_abs_seq #(
  parameter logic [15:0] RESET_PC = 16'hA004
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  din,
  input  logic [7:0]  pbank,
  input  logic [7:0]  dbank,
  input  logic [15:0] index,
  input  logic        emu,
  input  logic        wide,
  output logic [23:0] addr,
  output logic        rd,
  output logic        prog_ok,
  output logic        data_ok,
  output logic        done,
  output logic [15:0] value,
  output logic [15:0] pc
);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_OPL, S_OPH, S_FIX, S_DLO, S_DHI} st_t;

  st_t         st;
  logic [7:0]  pb_r, db_r, op_lo, op_hi, lo_byte;
  logic [15:0] idx_r;
  logic        w16;
  logic [23:0] ea;

  logic [8:0]  lo_sum;
  logic [23:0] ea_next;

  assign lo_sum  = {1'b0, op_lo} + {1'b0, idx_r[7:0]};
  assign ea_next = {db_r, din, op_lo} + {8'h00, idx_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      pb_r    <= '0;
      db_r    <= '0;
      idx_r   <= '0;
      w16     <= 1'b0;
      op_lo   <= '0;
      op_hi   <= '0;
      lo_byte <= '0;
      ea      <= '0;
      done    <= 1'b0;
      value   <= '0;
      pc      <= RESET_PC;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pb_r  <= pbank;
          db_r  <= dbank;
          idx_r <= emu ? {8'h00, index[7:0]} : index;
          w16   <= wide & ~emu;
          st    <= S_OPC;
        end
        S_OPC: st <= S_OPL;
        S_OPL: begin
          op_lo <= din;
          st    <= S_OPH;
        end
        S_OPH: begin
          op_hi <= din;
          ea    <= ea_next;
          st    <= lo_sum[8] ? S_FIX : S_DLO;
        end
        S_FIX: st <= S_DLO;
        S_DLO: begin
          lo_byte <= din;
          if (w16) st <= S_DHI;
          else begin
            st    <= S_IDLE;
            done  <= 1'b1;
            value <= {8'h00, din};
            pc    <= pc + 16'd3;
          end
        end
        S_DHI: begin
          st    <= S_IDLE;
          done  <= 1'b1;
          value <= {din, lo_byte};
          pc    <= pc + 16'd3;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    addr    = '0;
    rd      = 1'b1;
    prog_ok = 1'b0;
    data_ok = 1'b0;
    case (st)
      S_OPC: begin addr = {pb_r, pc};          prog_ok = 1'b1; data_ok = 1'b1; end
      S_OPL: begin addr = {pb_r, pc + 16'd1};  prog_ok = 1'b1; end
      S_OPH: begin addr = {pb_r, pc + 16'd2};  prog_ok = 1'b1; end
      S_FIX: addr = {db_r, op_hi, lo_sum[7:0]};
      S_DLO: begin addr = ea;                  data_ok = 1'b1; end
      S_DHI: begin addr = ea + 24'd1;          data_ok = 1'b1; end
      default: rd = 1'b0;
    endcase
  end

endmodule

module idx_abs_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [23:0] addr,
  input logic        rd,
  input logic        prog_ok,
  input logic        data_ok,
  input logic        done,
  input logic [15:0] pc
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd |-> (!prog_ok && !data_ok)); // R9
  AST_OPC_NEXT: assert property (@(posedge clk) disable iff (rst)
    (rd && prog_ok && data_ok) |=> (rd && prog_ok && !data_ok &&
      addr[23:16] == $past(addr[23:16]) && addr[15:0] == $past(addr[15:0]) + 16'd1)); // R1
  AST_FIX_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    (rd && !prog_ok && !data_ok) |=> (rd && data_ok && !prog_ok)); // R3
  AST_FIX_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rd && !prog_ok && !data_ok) |=> (addr[7:0] == $past(addr[7:0]))); // R2
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_PC: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && done) |-> (pc == $past(pc) + 16'd3)); // R7
  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && done) |-> $past(rd && data_ok && !prog_ok)); // R5
endmodule

bind idx_abs_seq idx_abs_seq_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd(rd), .prog_ok(prog_ok),
  .data_ok(data_ok), .done(done), .pc(pc)
);

// File: tb/tb_idx_abs_seq.sv
module tb_idx_abs_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  din;
  logic [7:0]  pbank = 8'h02, dbank = 8'h00;
  logic [15:0] index = 16'h0000;
  logic        emu = 1'b0, wide = 1'b0;
  logic [23:0] addr;
  logic        rd, prog_ok, data_ok, done;
  logic [15:0] value, pc;

  always #5 clk = ~clk;

  idx_abs_seq dut (.clk(clk), .rst(rst), .start(start), .din(din), .pbank(pbank),
    .dbank(dbank), .index(index), .emu(emu), .wide(wide), .addr(addr), .rd(rd),
    .prog_ok(prog_ok), .data_ok(data_ok), .done(done), .value(value), .pc(pc));

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  logic [23:0] prog_at = 24'h02A004;
  logic [7:0]  opl = 8'h00, oph = 8'h00;

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h5A);
  endfunction

  always_comb begin
    if (addr == prog_at) din = 8'hBD;
    else if (addr == {prog_at[23:16], prog_at[15:0] + 16'd1}) din = opl;
    else if (addr == {prog_at[23:16], prog_at[15:0] + 16'd2}) din = oph;
    else din = mem(addr);
  end

  logic [25:0] exp_bus[$];
  logic [15:0] exp_val[$];
  logic [15:0] exp_pc[$];
  string       exp_tag[$];
  string       exp_rtag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) if (!rst && !finished) begin
    if (rd) begin
      if (exp_bus.size() == 0) check(1'b0, "R8", "unexpected bus cycle", {6'd0, addr, prog_ok, data_ok}, 0);
      else begin
        logic [25:0] e;
        string t;
        e = exp_bus.pop_front();
        t = exp_tag.pop_front();
        check({addr, prog_ok, data_ok} == e, t, "bus cycle {addr,vp,vd}",
              {6'd0, addr, prog_ok, data_ok}, {6'd0, e});
      end
    end else check(!prog_ok && !data_ok, "R9", "qualifiers while idle", {prog_ok, data_ok}, 0);
    if (done) begin
      if (exp_val.size() == 0) check(1'b0, "R7", "unexpected done", value, 0);
      else begin
        logic [15:0] v, p;
        string t;
        v = exp_val.pop_front();
        p = exp_pc.pop_front();
        t = exp_rtag.pop_front();
        check(value == v, t, "loaded value", value, v);
        check(pc == p, "R7", "pc after done", pc, p);
      end
    end
  end

  task automatic run(input logic [7:0] db, input logic [15:0] op, input logic [15:0] ix,
                     input bit em, input bit wd, input bit poke, input string tag);
    logic [15:0] ixe, p0;
    logic [8:0]  ls;
    logic [23:0] ea;
    logic [7:0]  lo, hi;
    bit          w;
    p0  = prog_at[15:0];
    ixe = em ? {8'h00, ix[7:0]} : ix;
    w   = wd && !em;
    ls  = {1'b0, op[7:0]} + {1'b0, ixe[7:0]};
    ea  = {db, op} + {8'h00, ixe};
    exp_bus.push_back({prog_at[23:16], p0, 2'b11});          exp_tag.push_back("R1");
    exp_bus.push_back({prog_at[23:16], p0 + 16'd1, 2'b10});  exp_tag.push_back("R1");
    exp_bus.push_back({prog_at[23:16], p0 + 16'd2, 2'b10});  exp_tag.push_back("R1");
    if (ls[8]) begin
      exp_bus.push_back({db, op[15:8], ls[7:0], 2'b00});     exp_tag.push_back(em ? "R6" : "R3");
    end
    exp_bus.push_back({ea, 2'b01}); exp_tag.push_back(ls[8] ? "R2" : "R4");
    lo = mem(ea);
    hi = mem(ea + 24'd1);
    if (w) begin exp_bus.push_back({ea + 24'd1, 2'b01}); exp_tag.push_back("R5"); end
    exp_val.push_back(w ? {hi, lo} : {8'h00, lo});
    exp_rtag.push_back(em ? "R6" : "R5");
    exp_pc.push_back(p0 + 16'd3);
    opl = op[7:0]; oph = op[15:8];
    dbank = db; index = ix; emu = em; wide = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dbank = 8'hEE; index = 16'hFFFF; emu = ~em; wide = ~wd;
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    prog_at = {prog_at[23:16], p0 + 16'd3};
    check(exp_bus.size() == 0, "R4", "bus cycles left unseen", exp_bus.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!rd && !prog_ok && !data_ok && !done, "R9", "reset outputs", {rd, prog_ok, data_ok, done}, 0);
    check(addr == 24'h0 && value == 16'h0, "R9", "reset addr/value", addr, 0);
    check(pc == 16'hA004, "R9", "reset pc", pc, 16'hA004);
    @(negedge clk);
    run(8'h15, 16'h400A, 16'hDFFF, 1'b0, 1'b1, 1'b0, "R3");
    run(8'h15, 16'h4010, 16'h0020, 1'b0, 1'b1, 1'b0, "R4");
    run(8'h33, 16'h1200, 16'h0045, 1'b0, 1'b0, 1'b0, "R4");
    run(8'h07, 16'hFFF0, 16'h0020, 1'b0, 1'b0, 1'b0, "R2");
    run(8'hFF, 16'hFFFE, 16'h0001, 1'b0, 1'b1, 1'b0, "R5");
    run(8'h40, 16'h12F0, 16'hAB20, 1'b1, 1'b1, 1'b0, "R6");
    run(8'h40, 16'h1210, 16'hAB20, 1'b1, 1'b1, 1'b0, "R6");
    run(8'h21, 16'h30C0, 16'h0150, 1'b0, 1'b1, 1'b1, "R8");
    run(8'h22, 16'h5005, 16'h0003, 1'b0, 1'b0, 1'b1, "R8");
    repeat (3) @(negedge clk);
    check(exp_val.size() == 0, "R7", "results left unseen", exp_val.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule